// File: doc/BRIEF.md
# Vector Multiply-High Unit

This unit multiplies two 128-bit vectors lane by lane and keeps only the upper half of each lane's product. A 2-bit operation code selects the lane size and the signedness. Word lanes are 32 bits wide, four to a vector, and each result lane is the upper 32 bits of a 64-bit product. Doubleword lanes are 64 bits wide, two to a vector, and each result lane is the upper 64 bits of a 128-bit product. Operands are read as two's complement or as plain magnitudes.

There is one signed multiplier of (HALF_W+1) x (HALF_W+1) bits, shared over time. A word operation runs one multiply per lane, so it takes four steps. A doubleword lane is built from four half-width partial products with carries passed between them, so a doubleword operation takes eight steps. A request is a one-cycle `start_i` pulse that carries the operands and the code. The unit latches all three when it accepts the request. Completion is a one-cycle `done_o` pulse, and `res_o` holds the result.

Top module: `vmulhi_unit`

## Requirements
- R1: With op code 2'b00 (unsigned word), result bits [32i+31:32i] equal bits [63:32] of the unsigned product of operand lanes i, for i = 0..3. All-ones lanes give 0xFFFFFFFE.
- R2: With op code 2'b01 (signed word), each 32-bit result lane is bits [63:32] of the two's-complement product of the matching operand lanes. This includes lanes of mixed sign.
- R3: With op code 2'b10 (unsigned doubleword), result bits [64c+63:64c] equal bits [127:64] of the unsigned product of 64-bit operand lanes c, for c = 0..1. All-ones lanes give 0xFFFFFFFFFFFFFFFE.
- R4: With op code 2'b11 (signed doubleword), each 64-bit result lane is bits [127:64] of the two's-complement product of the matching operand lanes.
- R5: `done_o` is high for exactly one cycle. It rises 4 clock edges after the accepting edge in word modes and 8 edges after it in doubleword modes.
- R6: A `start_i` that arrives while an operation is in flight is ignored. It produces no extra `done_o` and does not change the result.
- R7: The op code and operands are taken when the request is accepted. Changes on those inputs later have no effect, and `res_o` changes only on the cycle `done_o` rises.
- R8: After a synchronous reset, `done_o` is low and `res_o` is zero.
- R9: The most negative value times itself gives 0x40000000 in every signed word lane and 0x4000000000000000 in every signed doubleword lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse; accepted when the unit is idle |
| op_i | input | 2 | Bit 1: doubleword lanes; bit 0: signed |
| a_i | input | 4*HALF_W | First vector operand |
| b_i | input | 4*HALF_W | Second vector operand |
| done_o | output | 1 | One-cycle completion pulse |
| res_o | output | 4*HALF_W | Packed high-half products |

## Verification
The hardest path to reach is the signed doubleword carry chain. A carry out of the middle partial products and a negative upper half must meet in the same lane, and random operands rarely produce that. The bench sweeps each operation over a grid of edge words (0, 1, 2, the signed extremes, all-ones and a mixed pattern), placed in both the high and low halves of every lane. A number of requests also send a second `start_i` during the run and scramble every input right after the accepting edge. Those requests confirm that the latched copy alone drives the result.

// File: rtl/vmulhi_pkg.sv
package vmulhi_pkg;
  typedef enum logic [1:0] {
    OP_UWORD = 2'b00,
    OP_SWORD = 2'b01,
    OP_UDBL  = 2'b10,
    OP_SDBL  = 2'b11
  } vmh_op_e;

  localparam int STEP_W     = 3;
  localparam int WORD_STEPS = 4;
  localparam int DBL_STEPS  = 8;
endpackage

// File: rtl/vmulhi_mul.sv
module vmulhi_mul #(
  parameter int OP_W = 33
) (
  input  logic signed [OP_W-1:0]   x_i,
  input  logic signed [OP_W-1:0]   y_i,
  output logic signed [2*OP_W-1:0] p_o
);
  assign p_o = x_i * y_i;
endmodule

// File: rtl/vmulhi_ctrl.sv
module vmulhi_ctrl #(
  parameter int STEP_W     = 3,
  parameter int WORD_STEPS = 4,
  parameter int DBL_STEPS  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              dbl_i,
  output logic              accept_o,
  output logic              busy_o,
  output logic              last_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] WORD_LAST = STEP_W'(WORD_STEPS - 1);
  localparam logic [STEP_W-1:0] DBL_LAST  = STEP_W'(DBL_STEPS - 1);

  assign accept_o = start_i && !busy_o;
  assign last_o   = busy_o && (step_o == (dbl_i ? DBL_LAST : WORD_LAST));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o <= 1'b0;
      step_o <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last_o;
      if (accept_o) begin
        busy_o <= 1'b1;
        step_o <= '0;
      end else if (busy_o) begin
        if (last_o) busy_o <= 1'b0;
        step_o <= step_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vmulhi_opsel.sv
module vmulhi_opsel #(
  parameter  int HALF_W = 32,
  localparam int VEC_W  = 4 * HALF_W
) (
  input  logic [1:0]        op_i,
  input  logic [VEC_W-1:0]  a_i,
  input  logic [VEC_W-1:0]  b_i,
  input  logic [2:0]        step_i,
  output logic signed [HALF_W:0] x_o,
  output logic signed [HALF_W:0] y_o
);
  function automatic logic signed [HALF_W:0] widen(input logic [HALF_W-1:0] v,
                                                   input logic sgn);
    return $signed({sgn & v[HALF_W-1], v});
  endfunction

  logic [HALF_W-1:0] a_w, b_w, a_lo, a_hi, b_lo, b_hi;
  int lane_base, chunk_base;
  logic sgn;

  always_comb begin
    sgn        = op_i[0];
    lane_base  = int'(step_i[1:0]) * HALF_W;
    chunk_base = int'(step_i[2]) * 2 * HALF_W;
    a_w  = a_i[lane_base +: HALF_W];
    b_w  = b_i[lane_base +: HALF_W];
    a_lo = a_i[chunk_base +: HALF_W];
    a_hi = a_i[chunk_base + HALF_W +: HALF_W];
    b_lo = b_i[chunk_base +: HALF_W];
    b_hi = b_i[chunk_base + HALF_W +: HALF_W];
    if (!op_i[1]) begin
      x_o = widen(a_w, sgn);
      y_o = widen(b_w, sgn);
    end else begin
      case (step_i[1:0])
        2'd0: begin x_o = widen(a_lo, 1'b0); y_o = widen(b_lo, 1'b0); end
        2'd1: begin x_o = widen(a_hi, sgn);  y_o = widen(b_lo, 1'b0); end
        2'd2: begin x_o = widen(a_lo, 1'b0); y_o = widen(b_hi, sgn);  end
        default: begin x_o = widen(a_hi, sgn); y_o = widen(b_hi, sgn); end
      endcase
    end
  end
endmodule

// File: rtl/vmulhi_unit.sv
module vmulhi_unit
  import vmulhi_pkg::*;
#(
  parameter  int HALF_W = 32,
  localparam int VEC_W  = 4 * HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  output logic             done_o,
  output logic [VEC_W-1:0] res_o
);
  localparam int PROD_W = 2 * (HALF_W + 1);

  logic [1:0]        op_q;
  logic [VEC_W-1:0]  a_q, b_q, work, work_n;
  logic              accept, busy, last;
  logic [STEP_W-1:0] step;
  logic signed [HALF_W:0]   mx, my;
  logic signed [PROD_W-1:0] prod, addend, sum, k_q, w_q;
  logic [HALF_W-1:0] klo_q;
  int lane_base, chunk_base;

  vmulhi_ctrl #(.STEP_W(STEP_W), .WORD_STEPS(WORD_STEPS), .DBL_STEPS(DBL_STEPS)) ctrl_i (
    .clk(clk), .rst(rst), .start_i(start_i), .dbl_i(op_q[1]),
    .accept_o(accept), .busy_o(busy), .last_o(last), .step_o(step), .done_o(done_o)
  );

  vmulhi_opsel #(.HALF_W(HALF_W)) opsel_i (
    .op_i(op_q), .a_i(a_q), .b_i(b_q), .step_i(step), .x_o(mx), .y_o(my)
  );

  vmulhi_mul #(.OP_W(HALF_W + 1)) mul_i (.x_i(mx), .y_i(my), .p_o(prod));

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else if (accept) begin
      op_q <= op_i;
      a_q  <= a_i;
      b_q  <= b_i;
    end
  end

  // Carry terms between partial products, then result packing.
  always_comb begin
    lane_base  = int'(step[1:0]) * HALF_W;
    chunk_base = int'(step[2]) * 2 * HALF_W;
    addend = '0;
    if (op_q[1]) begin
      case (step[1:0])
        2'd1:    addend = k_q;
        2'd2:    addend = $signed({{(PROD_W-HALF_W){1'b0}}, klo_q});
        2'd3:    addend = w_q + k_q;
        default: addend = '0;
      endcase
    end
    sum    = prod + addend;
    work_n = work;
    if (op_q[1]) begin
      if (step[1:0] == 2'd3) work_n[chunk_base +: 2*HALF_W] = sum[2*HALF_W-1:0];
    end else begin
      work_n[lane_base +: HALF_W] = prod[2*HALF_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      k_q   <= '0;
      w_q   <= '0;
      klo_q <= '0;
      work  <= '0;
      res_o <= '0;
    end else if (busy) begin
      work <= work_n;
      if (last) res_o <= work_n;
      if (op_q[1]) begin
        case (step[1:0])
          2'd0: k_q <= sum >>> HALF_W;
          2'd1: begin
            klo_q <= sum[HALF_W-1:0];
            w_q   <= sum >>> HALF_W;
          end
          2'd2: k_q <= sum >>> HALF_W;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/vmulhi_chk.sv
module vmulhi_chk #(
  parameter int HALF_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               start_i,
  input logic [1:0]         op_i,
  input logic               done_o,
  input logic [4*HALF_W-1:0] res_o
);
  logic       busy_m, dbl_m;
  logic [3:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_m  <= 1'b0;
      dbl_m   <= 1'b0;
      run_cnt <= '0;
    end else if (start_i && (!busy_m || done_o)) begin
      busy_m  <= 1'b1;
      dbl_m   <= op_i[1];
      run_cnt <= '0;
    end else if (done_o) begin
      busy_m  <= 1'b0;
      run_cnt <= '0;
    end else if (busy_m) begin
      run_cnt <= run_cnt + 1'b1;
    end
  end

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_latency_r5: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_cnt == (dbl_m ? 4'd8 : 4'd4)));

  p_no_spurious_done_r6: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_m);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(res_o));

  p_reset_state_r8: assert property (@(posedge clk)
    $past(rst) |-> (!done_o && res_o == '0));
endmodule

bind vmulhi_unit vmulhi_chk #(.HALF_W(HALF_W)) chk_i (
  .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
  .done_o(done_o), .res_o(res_o)
);

// File: tb/vmulhi_unit_tb_top.sv
`timescale 1ns/1ps
module vmulhi_unit_tb_top;
  localparam int HW = 32;
  localparam int VW = 4 * HW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic [1:0] op_i = '0;
  logic [VW-1:0] a_i = '0, b_i = '0;
  logic done_o;
  logic [VW-1:0] res_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] vals [8];

  vmulhi_unit #(.HALF_W(HW)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .done_o(done_o), .res_o(res_o)
  );

  always #2.5 clk = ~clk;

  function automatic logic [VW-1:0] model(input logic [1:0] op, input logic [VW-1:0] a,
                                          input logic [VW-1:0] b);
    logic [VW-1:0] r;
    r = '0;
    if (!op[1]) begin
      for (int i = 0; i < 4; i++) begin
        logic [63:0] x, y, p;
        x = {{32{op[0] & a[32*i+31]}}, a[32*i +: 32]};
        y = {{32{op[0] & b[32*i+31]}}, b[32*i +: 32]};
        p = x * y;
        r[32*i +: 32] = p[63:32];
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        logic [127:0] x, y, p;
        x = {{64{op[0] & a[64*c+63]}}, a[64*c +: 64]};
        y = {{64{op[0] & b[64*c+63]}}, b[64*c +: 64]};
        p = x * y;
        r[64*c +: 64] = p[127:64];
      end
    end
    return r;
  endfunction

  function automatic string op_tag(input logic [1:0] op);
    case (op)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [VW-1:0] act,
                       input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; optional second start while busy (R6). Inputs are scrambled
  // right after acceptance (R7).
  task automatic run_op(input logic [1:0] op, input logic [VW-1:0] a,
                        input logic [VW-1:0] b, input bit poke, output logic [VW-1:0] got);
    logic [VW-1:0] exp;
    int n;
    exp = model(op, a, b);
    start_i = 1'b1; op_i = op; a_i = a; b_i = b;
    @(negedge clk);
    start_i = 1'b0; op_i = ~op; a_i = ~a; b_i = a ^ {b[63:0], b[127:64]};
    n = 1;
    while (!done_o && n < 40) begin
      @(negedge clk);
      n++;
      start_i = (poke && n == 2);
    end
    start_i = 1'b0;
    check(n == (op[1] ? 9 : 5), "R5 latency", VW'(n), VW'(op[1] ? 9 : 5));
    check(res_o == exp, op_tag(op), res_o, exp);
    got = res_o;
    @(negedge clk);
    check(done_o == 1'b0, "R5 single-cycle done", VW'(done_o), '0);
    if (poke) begin
      bit extra;
      extra = 1'b0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (done_o) extra = 1'b1;
      end
      check(!extra, "R6 no extra done", VW'(extra), '0);
      check(res_o == exp, "R6 result kept", res_o, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [VW-1:0] got;
    vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h0000_0002;
    vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'hFFFF_FFFF;
    vals[6] = 32'h8000_0001; vals[7] = 32'h1234_5678;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done_o == 1'b0 && res_o == '0, "R8 reset state", res_o, '0);

    // R9: most negative value squared in signed modes
    run_op(2'b01, {4{32'h8000_0000}}, {4{32'h8000_0000}}, 1'b0, got);
    check(got == {4{32'h4000_0000}}, "R9 signed word", got, {4{32'h4000_0000}});
    run_op(2'b11, {2{64'h8000_0000_0000_0000}}, {2{64'h8000_0000_0000_0000}}, 1'b0, got);
    check(got == {2{64'h4000_0000_0000_0000}}, "R9 signed dword", got,
          {2{64'h4000_0000_0000_0000}});

    // R1/R3: all-ones operands in unsigned modes
    run_op(2'b00, '1, '1, 1'b0, got);
    check(got == {4{32'hFFFF_FFFE}}, "R1 all ones", got, {4{32'hFFFF_FFFE}});
    run_op(2'b10, '1, '1, 1'b0, got);
    check(got == {2{64'hFFFF_FFFF_FFFF_FFFE}}, "R3 all ones", got,
          {2{64'hFFFF_FFFF_FFFF_FFFE}});

    // R2/R4: mixed signs
    run_op(2'b01, {32'hFFFF_FFFF, 32'h0000_0003, 32'h8000_0000, 32'h7FFF_FFFF},
           {32'h0000_0001, 32'hFFFF_FFFE, 32'h7FFF_FFFF, 32'h8000_0000}, 1'b1, got);
    run_op(2'b11, {64'hFFFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF},
           {64'h0000_0000_0000_0003, 64'h8000_0000_0000_0000}, 1'b1, got);

    // Edge-value grid for each operation (R1..R4, with R6/R7 pokes)
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 8; i++) begin
        for (int j = 0; j < 8; j++) begin
          run_op(op[1:0],
                 {vals[i], vals[j], vals[(i+3)%8], vals[(j+5)%8]},
                 {vals[j], vals[(i+1)%8], vals[i], vals[(j+2)%8]},
                 ((i + j) % 5 == 0), got);
        end
      end
    end

    // Random operands per operation
    for (int op = 0; op < 4; op++) begin
      for (int r = 0; r < 25; r++) begin
        run_op(op[1:0], {$urandom, $urandom, $urandom, $urandom},
               {$urandom, $urandom, $urandom, $urandom}, (r % 4 == 0), got);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule